// File: doc/BRIEF.md
# Edge-Timed Digital Delay Cell

This block reproduces a single-bit input on its output after a number of clock cycles that depends on the direction of each transition. A rising input edge is delayed by a rise total, a falling edge by a fall total; each total is a base delay plus a separate load term, so the timing of a driven net can be modelled as an intrinsic part and a load-dependent part.

One mode input selects between two behaviours. In inertial mode (`transport_en` = 0) the input must hold a new level for at least the applicable delay before the output follows, so short glitches are swallowed. In transport mode (`transport_en` = 1) every input transition is shifted forward in time unchanged, however short the pulse. Each transition is timed with the delay settings present when the transition is sampled, so a configuration change only affects transitions seen after it.

Top module: `edge_delay_cell`

## Requirements
- R1: `rst` is synchronous and active high; while it is asserted and after it is released, `dout` is 0 and no earlier transition is pending.
- R2: A rising transition of `din` sampled at clock edge n appears on `dout` at clock edge n+D, where D is the rise total; this holds in both modes.
- R3: A falling transition uses the fall total instead of the rise total.
- R4: Each total is the base delay plus the load term of the same direction (`rise_base`+`rise_load`, `fall_base`+`fall_load`).
- R5: A total of 0 is treated as 1 cycle, and a total above MAX_DLY (default 64) is limited to MAX_DLY.
- R6: In inertial mode, a pulse narrower than the delay of its leading transition never reaches `dout` (the output does not change at all).
- R7: In inertial mode, a pulse whose width is equal to or larger than the delay of its leading edge passes; with rise total R and fall total F, a high pulse of width W appears with width W+F-R.
- R8: In transport mode, every pulse passes, even one narrower than the delay; with equal rise and fall totals its width is unchanged.
- R9: A change of the delay inputs does not alter the timing of a transition that was already sampled; later transitions use the new values.
- R10: In transport mode, when two transitions are scheduled onto the same output cycle, the one sampled later decides the output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data input to be delayed |
| transport_en | input | 1 | 0 = inertial mode, 1 = transport mode |
| rise_base | input | DLY_W (7) | Base delay for low-to-high transitions, in cycles |
| fall_base | input | DLY_W (7) | Base delay for high-to-low transitions, in cycles |
| rise_load | input | LOAD_W (4) | Extra load delay added to rising transitions |
| fall_load | input | LOAD_W (4) | Extra load delay added to falling transitions |
| dout | output | 1 | Delayed output |

## Verification
Single edges with differing rise and fall settings separate the two directions and show that the load term is added, while zero and oversized totals probe both ends of the clamp. Pulses narrower than, equal to and wider than the delay are driven in each mode: the narrow ones tell inertial cancellation apart from transport shifting, and the equal-width pulse pins down which side of the boundary passes. A delay change made while a transition is in flight shows that timing is captured at sampling, and a transport pulse whose falling edge lands on the same cycle as its rising edge exposes the later-wins rule.

// File: rtl/edly_pkg.sv
package edly_pkg;

   // One entry of the transport event wheel: a scheduled output value.
   typedef struct packed {
      logic vld;
      logic val;
   } edly_slot_t;

endpackage

// File: rtl/edly_delay_sel.sv
module edly_delay_sel #(
   parameter int MAX_DLY = 64,
   parameter int DLY_W   = 7,
   parameter int LOAD_W  = 4,
   parameter int CNT_W   = 7
) (
   input  logic [DLY_W-1:0]  rise_base_i,
   input  logic [DLY_W-1:0]  fall_base_i,
   input  logic [LOAD_W-1:0] rise_load_i,
   input  logic [LOAD_W-1:0] fall_load_i,
   output logic [CNT_W-1:0]  rise_tot_o,
   output logic [CNT_W-1:0]  fall_tot_o
);

   localparam int SUM_W = DLY_W + 1;
   localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(MAX_DLY);

   logic [DLY_W-1:0]  base [2];
   logic [LOAD_W-1:0] load [2];
   logic [CNT_W-1:0]  tot  [2];

   assign base[0] = rise_base_i;
   assign base[1] = fall_base_i;
   assign load[0] = rise_load_i;
   assign load[1] = fall_load_i;

   // Direction 0 = rise, 1 = fall; both share the same clamp.
   for (genvar d = 0; d < 2; d++) begin : g_dir
      logic [SUM_W-1:0] sum;
      always_comb begin
         sum = {1'b0, base[d]} + SUM_W'(load[d]);
         if (sum == '0)
            tot[d] = CNT_W'(1);
         else if (sum > MAX_SUM)
            tot[d] = CNT_W'(MAX_DLY);
         else
            tot[d] = CNT_W'(sum);
      end
   end

   assign rise_tot_o = tot[0];
   assign fall_tot_o = tot[1];

   always_comb begin
      assert_total_range_R5: assert ((rise_tot_o != '0) && (fall_tot_o != '0)
                                     && (rise_tot_o <= CNT_W'(MAX_DLY))
                                     && (fall_tot_o <= CNT_W'(MAX_DLY)));
   end

endmodule

// File: rtl/edly_inertial.sv
module edly_inertial #(
   parameter int MAX_DLY = 64,
   parameter int CNT_W   = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic             din_i,
   input  logic             dout_i,
   input  logic [CNT_W-1:0] rise_tot_i,
   input  logic [CNT_W-1:0] fall_tot_i,
   output logic             upd_o,
   output logic             upd_val_o
);

   logic             pend_vld;
   logic             pend_val;
   logic [CNT_W-1:0] pend_cnt;
   logic             fire;
   logic             out_nxt;
   logic [CNT_W-1:0] dly_sel;

   assign fire    = pend_vld && (pend_cnt == '0);
   assign out_nxt = fire ? pend_val : dout_i;
   assign dly_sel = din_i ? rise_tot_i : fall_tot_i;

   always_ff @(posedge clk) begin
      if (rst || !en_i) begin
         pend_vld <= 1'b0;
         pend_val <= 1'b0;
         pend_cnt <= '0;
      end else if (din_i == out_nxt) begin
         // input is back at (or equal to) the output level: nothing pending
         pend_vld <= 1'b0;
      end else if (fire || !pend_vld) begin
         // new target level; its delay is fixed now
         pend_vld <= 1'b1;
         pend_val <= din_i;
         pend_cnt <= dly_sel - 1'b1;
      end else begin
         pend_cnt <= pend_cnt - 1'b1;
      end
   end

   assign upd_o     = en_i && fire;
   assign upd_val_o = pend_val;

   assert_pending_differs_R6: assert property (@(posedge clk) disable iff (rst)
      pend_vld |-> (pend_val != dout_i));

   assert_update_toggles_R2: assert property (@(posedge clk) disable iff (rst)
      upd_o |-> (upd_val_o != dout_i));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
      pend_vld |-> (pend_cnt < CNT_W'(MAX_DLY)));

endmodule

// File: rtl/edly_transport.sv
module edly_transport
   import edly_pkg::*;
#(
   parameter int MAX_DLY = 64,
   parameter int CNT_W   = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic             din_i,
   input  logic             din_prev_i,
   input  logic [CNT_W-1:0] rise_tot_i,
   input  logic [CNT_W-1:0] fall_tot_i,
   output logic             upd_o,
   output logic             upd_val_o
);

   edly_slot_t       slots [MAX_DLY];
   logic             ins;
   logic [CNT_W-1:0] ins_idx;

   assign ins     = din_i ^ din_prev_i;
   assign ins_idx = (din_i ? rise_tot_i : fall_tot_i) - 1'b1;

   // Slot k holds the value due k+1 clock edges from now; the wheel moves
   // one slot per cycle and a new edge overwrites whatever shifts in.
   for (genvar g = 0; g < MAX_DLY; g++) begin : g_slot
      edly_slot_t from_up;
      if (g == MAX_DLY - 1) begin : g_top
         assign from_up = '0;
      end else begin : g_mid
         assign from_up = slots[g+1];
      end
      always_ff @(posedge clk) begin
         if (rst || !en_i)
            slots[g] <= '0;
         else if (ins && (ins_idx == CNT_W'(g)))
            slots[g] <= '{vld: 1'b1, val: din_i};
         else
            slots[g] <= from_up;
      end
   end

   assign upd_o     = en_i && slots[0].vld;
   assign upd_val_o = slots[0].val;

   assert_idle_no_event_R8: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> !upd_o);

endmodule

// File: rtl/edge_delay_cell.sv
module edge_delay_cell #(
   parameter int MAX_DLY = 64,
   parameter int DLY_W   = 7,
   parameter int LOAD_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din,
   input  logic              transport_en,
   input  logic [DLY_W-1:0]  rise_base,
   input  logic [DLY_W-1:0]  fall_base,
   input  logic [LOAD_W-1:0] rise_load,
   input  logic [LOAD_W-1:0] fall_load,
   output logic              dout
);

   localparam int CNT_W = $clog2(MAX_DLY + 1);

   if (MAX_DLY < 1) begin : g_chk_depth
      $error("edge_delay_cell: MAX_DLY must be at least 1");
   end
   if (DLY_W < LOAD_W) begin : g_chk_load
      $error("edge_delay_cell: LOAD_W must not exceed DLY_W");
   end
   if ((2 ** DLY_W) - 1 < MAX_DLY) begin : g_chk_base
      $error("edge_delay_cell: DLY_W too narrow to express MAX_DLY");
   end

   logic             din_q;
   logic [CNT_W-1:0] rise_tot;
   logic [CNT_W-1:0] fall_tot;
   logic             i_upd, i_val;
   logic             t_upd, t_val;
   logic             sel_upd, sel_val;

   edly_delay_sel #(
      .MAX_DLY(MAX_DLY), .DLY_W(DLY_W), .LOAD_W(LOAD_W), .CNT_W(CNT_W)
   ) u_dsel (
      .rise_base_i(rise_base),
      .fall_base_i(fall_base),
      .rise_load_i(rise_load),
      .fall_load_i(fall_load),
      .rise_tot_o (rise_tot),
      .fall_tot_o (fall_tot)
   );

   edly_inertial #(.MAX_DLY(MAX_DLY), .CNT_W(CNT_W)) u_inert (
      .clk       (clk),
      .rst       (rst),
      .en_i      (!transport_en),
      .din_i     (din),
      .dout_i    (dout),
      .rise_tot_i(rise_tot),
      .fall_tot_i(fall_tot),
      .upd_o     (i_upd),
      .upd_val_o (i_val)
   );

   edly_transport #(.MAX_DLY(MAX_DLY), .CNT_W(CNT_W)) u_trans (
      .clk       (clk),
      .rst       (rst),
      .en_i      (transport_en),
      .din_i     (din),
      .din_prev_i(din_q),
      .rise_tot_i(rise_tot),
      .fall_tot_i(fall_tot),
      .upd_o     (t_upd),
      .upd_val_o (t_val)
   );

   assign sel_upd = transport_en ? t_upd : i_upd;
   assign sel_val = transport_en ? t_val : i_val;

   always_ff @(posedge clk) begin
      if (rst) begin
         din_q <= 1'b0;
         dout  <= 1'b0;
      end else begin
         din_q <= din;
         if (sel_upd)
            dout <= sel_val;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (dout == 1'b0));

endmodule

// File: tb/sim_edge_delay_cell.sv
module sim_edge_delay_cell;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       din = 1'b0;
   logic       transport_en = 1'b0;
   logic [6:0] rise_base = 7'd1;
   logic [6:0] fall_base = 7'd1;
   logic [3:0] rise_load = 4'd0;
   logic [3:0] fall_load = 4'd0;
   logic       dout;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   edge_delay_cell u0 (
      .clk(clk), .rst(rst), .din(din), .transport_en(transport_en),
      .rise_base(rise_base), .fall_base(fall_base),
      .rise_load(rise_load), .fall_load(fall_load), .dout(dout)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      din = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic config_set(input int rb, input int fb, input int rl,
                             input int fl, input bit tr);
      rise_base = 7'(rb);
      fall_base = 7'(fb);
      rise_load = 4'(rl);
      fall_load = 4'(fl);
      transport_en = tr;
   endtask

   // Drive din to lvl at the current negedge; cycles until dout follows.
   task automatic measure(input bit lvl, output int lat);
      lat = -1;
      din = lvl;
      for (int i = 1; i <= 200; i++) begin
         @(negedge clk);
         if (dout == lvl) begin
            lat = i - 1;
            break;
         end
      end
   endtask

   // High pulse of width w cycles, observe ncyc cycles.
   task automatic run_pulse(input int w, input int ncyc, output int rise_at,
                            output int high_len, output int toggles);
      bit last;
      rise_at = -1;
      high_len = 0;
      toggles = 0;
      last = dout;
      din = 1'b1;
      for (int c = 1; c <= ncyc; c++) begin
         @(negedge clk);
         if (dout != last) toggles++;
         last = dout;
         if (dout && rise_at < 0) rise_at = c - 1;
         if (dout) high_len++;
         if (c == w) din = 1'b0;
      end
   endtask

   task automatic t_reset();
      int ones = 0;
      rst = 1'b1;
      din = 1'b1;
      repeat (10) begin
         @(negedge clk);
         if (dout) ones++;
      end
      check("R1 dout held low during reset", ones, 0);
      din = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 dout after reset", int'(dout), 0);
   endtask

   task automatic t_directions();
      int lat;
      do_reset();
      config_set(5, 9, 0, 0, 1'b0);
      measure(1'b1, lat);
      check("R2 inertial rise latency", lat, 5);
      repeat (3) @(negedge clk);
      measure(1'b0, lat);
      check("R3 inertial fall latency", lat, 9);
      do_reset();
      config_set(5, 9, 0, 0, 1'b1);
      measure(1'b1, lat);
      check("R2 transport rise latency", lat, 5);
      repeat (3) @(negedge clk);
      measure(1'b0, lat);
      check("R3 transport fall latency", lat, 9);
   endtask

   task automatic t_load();
      int lat;
      do_reset();
      config_set(3, 2, 4, 6, 1'b0);
      measure(1'b1, lat);
      check("R4 rise base+load", lat, 7);
      repeat (2) @(negedge clk);
      measure(1'b0, lat);
      check("R4 fall base+load", lat, 8);
   endtask

   task automatic t_clamp();
      int lat;
      do_reset();
      config_set(0, 60, 0, 15, 1'b0);
      measure(1'b1, lat);
      check("R5 zero total acts as 1", lat, 1);
      repeat (2) @(negedge clk);
      measure(1'b0, lat);
      check("R5 total limited to 64", lat, 64);
   endtask

   task automatic t_inertial();
      int ra, hl, tg;
      do_reset();
      config_set(8, 8, 0, 0, 1'b0);
      run_pulse(5, 30, ra, hl, tg);
      check("R6 narrow pulse cancelled", tg, 0);
      run_pulse(7, 30, ra, hl, tg);
      check("R6 pulse one below delay cancelled", tg, 0);
      do_reset();
      config_set(5, 5, 0, 0, 1'b0);
      run_pulse(5, 30, ra, hl, tg);
      check("R7 equal-width pulse rise", ra, 5);
      check("R7 equal-width pulse width", hl, 5);
      run_pulse(10, 30, ra, hl, tg);
      check("R7 wide pulse width", hl, 10);
      do_reset();
      config_set(4, 6, 0, 0, 1'b0);
      run_pulse(8, 30, ra, hl, tg);
      check("R7 asymmetric rise", ra, 4);
      check("R7 asymmetric width W+F-R", hl, 10);
   endtask

   task automatic t_transport();
      int ra, hl, tg;
      do_reset();
      config_set(8, 8, 0, 0, 1'b1);
      run_pulse(2, 30, ra, hl, tg);
      check("R8 narrow pulse rise", ra, 8);
      check("R8 narrow pulse width", hl, 2);
      run_pulse(1, 30, ra, hl, tg);
      check("R8 single-cycle pulse width", hl, 1);
      check("R8 single-cycle pulse toggles", tg, 2);
   endtask

   task automatic t_config_change();
      int lat;
      do_reset();
      config_set(10, 10, 0, 0, 1'b0);
      lat = -1;
      din = 1'b1;
      for (int i = 1; i <= 100; i++) begin
         @(negedge clk);
         if (i == 1) rise_base = 7'd3;
         if (dout && lat < 0) lat = i - 1;
      end
      check("R9 in-flight edge keeps old delay", lat, 10);
      config_set(10, 10, 0, 0, 1'b1);
      do_reset();
      lat = -1;
      din = 1'b1;
      for (int i = 1; i <= 100; i++) begin
         @(negedge clk);
         if (i == 1) rise_base = 7'd3;
         if (dout && lat < 0) lat = i - 1;
      end
      check("R9 transport in-flight edge keeps old delay", lat, 10);
      din = 1'b0;
      repeat (20) @(negedge clk);
      measure(1'b1, lat);
      check("R9 later edge uses new delay", lat, 3);
   endtask

   task automatic t_collision();
      int ra, hl, tg;
      do_reset();
      config_set(10, 5, 0, 0, 1'b1);
      run_pulse(5, 30, ra, hl, tg);
      check("R10 same-cycle events later wins", tg, 0);
      do_reset();
      config_set(10, 5, 0, 0, 1'b1);
      run_pulse(6, 30, ra, hl, tg);
      check("R10 non-colliding events both apply", hl, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_directions();
      t_load();
      t_clamp();
      t_inertial();
      t_transport();
      t_config_change();
      t_collision();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule